// File: doc/BRIEF.md
# Reset Release Time-out Sequencer

This block decides when a small processor core may leave reset after the supply comes up, after a supply sag, or after the external reset pin is asserted. A power-on pulse starts a chain of waits, each of which can be enabled or skipped:

- a power-up delay counted on a slow RC tick;
- a main-oscillator start-up count for the crystal-type clock modes;
- a PLL lock wait for the PLL clock mode.

The core reset output stays asserted until every wait that applies has finished.

A brown-out path watches an already synchronized low-supply flag. The flag must stay set for a filter time before the core is put into brown-out reset, so short dips do nothing. Once the supply recovers, the power-up delay runs again from zero.

The external reset pin is synchronized inside the block and only gates the final release. The waits run whether or not the pin is held low. If the pin is released after all waits have finished, the core starts two clocks later. The current stage is brought out as a 3-bit code.

Top module: `rst_timeout_seq`

## Requirements
- R1: While `powerOnPulse` is high, `stage` reads POR on the clock after each edge that samples it, and `coreReset` is 1. Stage codes are POR=0, PWRT=1, OST=2, PLL=3, RUN=4, BOR=5.
- R2: The power-up delay (stage PWRT) runs only when `timerEnN` is 0, which makes that input active low. It lasts 2^PUT_BITS `rcTick` pulses (2048 by default).
- R3: `oscMode` is coded as follows: 0 is low-power crystal, 1 is crystal, 2 is high-speed crystal, 3 is high-speed crystal with PLL, and 4 to 7 are RC modes. The oscillator start-up count (stage OST) of OST_COUNT `oscTick` pulses runs only in modes 0 to 3. It runs only on the power-on path, after PWRT when PWRT is enabled.
- R4: In mode 3 only, a PLL lock wait (stage PLL) of LOCK_TICKS `rcTick` pulses follows OST.
- R5: When no stage applies (RC mode with `timerEnN`=1), `stage` is RUN right after the first clock edge at which `powerOnPulse` is low.
- R6: With `brownEn`=1, `lowSupply` high across more than BOR_FILT consecutive `rcTick` pulses moves the stage to BOR. A dip covering at most BOR_FILT ticks has no effect. With `brownEn`=0, BOR is never entered.
- R7: The stage stays BOR while `lowSupply` is high. At the first edge with it low, the stage goes to PWRT if `timerEnN`=0 and otherwise to RUN. A PWRT entered from BOR runs its full count from zero and goes straight to RUN, with no OST.
- R8: A filtered brown-out during PWRT, OST, PLL or RUN enters BOR. It wins over a stage completion that falls in the same cycle.
- R9: `extResetN` passes through two flops. `coreReset` is 1 whenever the stage is not RUN or the synchronized pin is low. A rising pin edge therefore releases `coreReset` at the second clock edge after it.
- R10: With one tick per clock, `stage` becomes RUN at edge index T after `powerOnPulse` falls, where edge 0 is the first edge that samples it low. T is the sum of (length+1) over the applicable stages, and `coreReset` falls at that same edge when the pin is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| powerOnPulse | input | 1 | Power-on pulse, active high, synchronous |
| lowSupply | input | 1 | Synchronized under-voltage flag |
| extResetN | input | 1 | External reset pin, active low, asynchronous |
| oscMode | input | 3 | Oscillator mode code (see R3) |
| timerEnN | input | 1 | Power-up delay enable, active low |
| brownEn | input | 1 | Brown-out reset enable |
| rcTick | input | 1 | One-clock pulse per slow RC period |
| oscTick | input | 1 | One-clock pulse per main-oscillator period |
| coreReset | output | 1 | Reset to the core, active high |
| stage | output | 3 | Current stage code (see R1) |

## Verification
A filtered brown-out trip and the end of the power-up count can fall in the same clock. Brown-out must win, so the core never leaves on a count that ran through a sag. The bench provokes this by raising `lowSupply` exactly BOR_FILT edges before the power-up count ends, and it expects BOR and not OST or RUN at that edge. A second pairing releases the external pin long after all waits are over. The bench judges it by `coreReset` falling exactly two edges later and not earlier.

// File: rtl/rst_timeout_seq_pkg.sv
package rst_timeout_seq_pkg;

  typedef enum logic [2:0] {
    ST_POR  = 3'd0,
    ST_PWRT = 3'd1,
    ST_OST  = 3'd2,
    ST_PLL  = 3'd3,
    ST_RUN  = 3'd4,
    ST_BOR  = 3'd5
  } seqState_t;

  // control -> datapath
  typedef struct packed {
    logic clrTimer;
    logic cntRc;
    logic cntOsc;
  } seqStrobe_t;

  // datapath -> control
  typedef struct packed {
    logic pwrtDone;
    logic ostDone;
    logic lockDone;
    logic borTrip;
    logic pinHigh;
  } seqFlags_t;

  localparam logic [2:0] MODE_HS_PLL = 3'd3;

  function automatic logic modeNeedsOst(input logic [2:0] mode);
    return mode <= MODE_HS_PLL;
  endfunction

  function automatic logic modeHasPll(input logic [2:0] mode);
    return mode == MODE_HS_PLL;
  endfunction

endpackage

// File: rtl/rst_timeout_seq_dp.sv
module rst_timeout_seq_dp
  import rst_timeout_seq_pkg::*;
#(
  parameter int PUT_BITS   = 11,
  parameter int OST_COUNT  = 1024,
  parameter int LOCK_TICKS = 62,
  parameter int BOR_FILT   = 4
) (
  input  logic       clk,
  input  logic       powerOnPulse,
  input  logic       lowSupply,
  input  logic       brownEn,
  input  logic       extResetN,
  input  logic       rcTick,
  input  logic       oscTick,
  input  seqStrobe_t strobe,
  output seqFlags_t  flags
);

  localparam int CNT_W  = PUT_BITS + 1;
  localparam int FILT_W = $clog2(BOR_FILT + 1);
  localparam logic [CNT_W-1:0]  PWRT_END = CNT_W'(1 << PUT_BITS);
  localparam logic [CNT_W-1:0]  OST_END  = CNT_W'(OST_COUNT);
  localparam logic [CNT_W-1:0]  LOCK_END = CNT_W'(LOCK_TICKS);
  localparam logic [FILT_W-1:0] FILT_END = FILT_W'(BOR_FILT);

  logic [CNT_W-1:0]  tmrCnt;
  logic [FILT_W-1:0] filtCnt;
  logic              pinMeta;
  logic              pinSync;
  logic              tmrStep;

  // one shared stage timer, fed by whichever tick the current stage uses
  assign tmrStep = (strobe.cntRc && rcTick) || (strobe.cntOsc && oscTick);

  always_ff @(posedge clk) begin
    if (powerOnPulse || strobe.clrTimer) begin
      tmrCnt <= '0;
    end else if (tmrStep && (tmrCnt != {CNT_W{1'b1}})) begin
      tmrCnt <= tmrCnt + 1'b1;
    end
  end

  // brown-out glitch filter: consecutive RC ticks with the flag set
  always_ff @(posedge clk) begin
    if (powerOnPulse || !lowSupply || !brownEn) begin
      filtCnt <= '0;
    end else if (rcTick && (filtCnt != FILT_END)) begin
      filtCnt <= filtCnt + 1'b1;
    end
  end

  // external pin synchronizer
  always_ff @(posedge clk) begin
    pinMeta <= extResetN;
    pinSync <= pinMeta;
  end

  always_comb begin
    flags.pwrtDone = (tmrCnt == PWRT_END);
    flags.ostDone  = (tmrCnt == OST_END);
    flags.lockDone = (tmrCnt == LOCK_END);
    flags.borTrip  = brownEn && lowSupply && (filtCnt == FILT_END);
    flags.pinHigh  = pinSync;
  end

endmodule

// File: rtl/rst_timeout_seq_ctrl.sv
module rst_timeout_seq_ctrl
  import rst_timeout_seq_pkg::*;
(
  input  logic       clk,
  input  logic       powerOnPulse,
  input  logic       lowSupply,
  input  logic       timerEnN,
  input  logic [2:0] oscMode,
  input  seqFlags_t  flags,
  output seqState_t  state,
  output seqStrobe_t strobe
);

  seqState_t stateNext;
  logic      borPath;
  logic      needOst;
  logic      needPll;

  assign needOst = modeNeedsOst(oscMode);
  assign needPll = modeHasPll(oscMode);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_POR: begin
        if (!timerEnN)    stateNext = ST_PWRT;
        else if (needOst) stateNext = ST_OST;
        else              stateNext = ST_RUN;
      end
      ST_PWRT: begin
        if (flags.borTrip)       stateNext = ST_BOR;
        else if (flags.pwrtDone) begin
          if (borPath)      stateNext = ST_RUN;
          else if (needOst) stateNext = ST_OST;
          else              stateNext = ST_RUN;
        end
      end
      ST_OST: begin
        if (flags.borTrip)      stateNext = ST_BOR;
        else if (flags.ostDone) stateNext = needPll ? ST_PLL : ST_RUN;
      end
      ST_PLL: begin
        if (flags.borTrip)       stateNext = ST_BOR;
        else if (flags.lockDone) stateNext = ST_RUN;
      end
      ST_RUN: begin
        if (flags.borTrip) stateNext = ST_BOR;
      end
      ST_BOR: begin
        if (!lowSupply) stateNext = timerEnN ? ST_RUN : ST_PWRT;
      end
      default: stateNext = ST_POR;
    endcase
  end

  always_ff @(posedge clk) begin
    if (powerOnPulse) state <= ST_POR;
    else              state <= stateNext;
  end

  // remembers that the current climb started from a brown-out, so OST is skipped
  always_ff @(posedge clk) begin
    if (powerOnPulse || state == ST_POR) borPath <= 1'b0;
    else if (state == ST_BOR)            borPath <= 1'b1;
  end

  always_comb begin
    strobe.clrTimer = powerOnPulse || (stateNext != state);
    strobe.cntRc    = (state == ST_PWRT) || (state == ST_PLL);
    strobe.cntOsc   = (state == ST_OST);
  end

endmodule

// File: rtl/rst_timeout_seq.sv
module rst_timeout_seq
  import rst_timeout_seq_pkg::*;
#(
  parameter int PUT_BITS   = 11,
  parameter int OST_COUNT  = 1024,
  parameter int LOCK_TICKS = 62,
  parameter int BOR_FILT   = 4
) (
  input  logic       clk,
  input  logic       powerOnPulse,
  input  logic       lowSupply,
  input  logic       extResetN,
  input  logic [2:0] oscMode,
  input  logic       timerEnN,
  input  logic       brownEn,
  input  logic       rcTick,
  input  logic       oscTick,
  output logic       coreReset,
  output logic [2:0] stage
);

  seqState_t  state;
  seqStrobe_t strobe;
  seqFlags_t  flags;

  rst_timeout_seq_ctrl ctrlInst (
    .clk          (clk),
    .powerOnPulse (powerOnPulse),
    .lowSupply    (lowSupply),
    .timerEnN     (timerEnN),
    .oscMode      (oscMode),
    .flags        (flags),
    .state        (state),
    .strobe       (strobe)
  );

  rst_timeout_seq_dp #(
    .PUT_BITS   (PUT_BITS),
    .OST_COUNT  (OST_COUNT),
    .LOCK_TICKS (LOCK_TICKS),
    .BOR_FILT   (BOR_FILT)
  ) dpInst (
    .clk          (clk),
    .powerOnPulse (powerOnPulse),
    .lowSupply    (lowSupply),
    .brownEn      (brownEn),
    .extResetN    (extResetN),
    .rcTick       (rcTick),
    .oscTick      (oscTick),
    .strobe       (strobe),
    .flags        (flags)
  );

  assign stage     = state;
  assign coreReset = (state != ST_RUN) || !flags.pinHigh;

endmodule

// File: rtl/rst_timeout_seq_chk.sv
module rst_timeout_seq_chk (
  input logic       clk,
  input logic       powerOnPulse,
  input logic       lowSupply,
  input logic       extResetN,
  input logic [2:0] oscMode,
  input logic       brownEn,
  input logic       coreReset,
  input logic [2:0] stage
);

  assert_por_return_R1: assert property (@(posedge clk)
    powerOnPulse |=> (stage == 3'd0));

  assert_ost_entry_R3: assert property (@(posedge clk) disable iff (powerOnPulse)
    ((stage == 3'd2) && ($past(stage) != 3'd2)) |-> (($past(stage) == 3'd1) || ($past(stage) == 3'd0)));

  assert_pll_mode_R4: assert property (@(posedge clk) disable iff (powerOnPulse)
    (stage == 3'd3) |-> (oscMode == 3'd3));

  assert_no_bor_when_off_R6: assert property (@(posedge clk) disable iff (powerOnPulse)
    (!brownEn && (stage != 3'd5)) |=> (stage != 3'd5));

  assert_bor_exit_R7: assert property (@(posedge clk) disable iff (powerOnPulse)
    ((stage == 3'd5) && !lowSupply) |=> ((stage == 3'd1) || (stage == 3'd4)));

  assert_release_in_run_R9: assert property (@(posedge clk) disable iff (powerOnPulse)
    $fell(coreReset) |-> (stage == 3'd4));

  assert_pin_holds_reset_R9: assert property (@(posedge clk) disable iff (powerOnPulse)
    !extResetN |=> ##1 coreReset);

endmodule

bind rst_timeout_seq rst_timeout_seq_chk chkInst (
  .clk          (clk),
  .powerOnPulse (powerOnPulse),
  .lowSupply    (lowSupply),
  .extResetN    (extResetN),
  .oscMode      (oscMode),
  .brownEn      (brownEn),
  .coreReset    (coreReset),
  .stage        (stage)
);

// File: tb/rst_timeout_seq_test.sv
`timescale 1ns/1ps
module rst_timeout_seq_test;

  localparam int PWRT_LEN = 2048;
  localparam int OST_LEN  = 1024;
  localparam int LOCK_LEN = 62;
  localparam int FILT     = 4;
  localparam logic [2:0] S_POR = 3'd0, S_PWRT = 3'd1, S_OST = 3'd2,
                         S_PLL = 3'd3, S_RUN = 3'd4, S_BOR = 3'd5;

  logic       clk = 1'b0;
  logic       powerOnPulse = 1'b1;
  logic       lowSupply = 1'b0;
  logic       extResetN = 1'b1;
  logic [2:0] oscMode = 3'd4;
  logic       timerEnN = 1'b1;
  logic       brownEn = 1'b0;
  logic       rcTick = 1'b1;
  logic       oscTick = 1'b1;
  logic       coreReset;
  logic [2:0] stage;

  int nChecks = 0;
  int nErrors = 0;
  int edgeIdx;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  rst_timeout_seq uut (
    .clk(clk), .powerOnPulse(powerOnPulse), .lowSupply(lowSupply),
    .extResetN(extResetN), .oscMode(oscMode), .timerEnN(timerEnN),
    .brownEn(brownEn), .rcTick(rcTick), .oscTick(oscTick),
    .coreReset(coreReset), .stage(stage)
  );

  function automatic int expRelease(input logic [2:0] mode, input logic enN);
    int t = 0;
    if (!enN)        t += PWRT_LEN + 1;
    if (mode <= 3'd3) t += OST_LEN + 1;
    if (mode == 3'd3) t += LOCK_LEN + 1;
    return t;
  endfunction

  function automatic logic [2:0] expFirst(input logic [2:0] mode, input logic enN);
    if (!enN)         return S_PWRT;
    if (mode <= 3'd3) return S_OST;
    return S_RUN;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nErrors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic stepTo(input int k);
    while (edgeIdx < k) begin
      @(negedge clk);
      edgeIdx++;
    end
  endtask

  task automatic steps(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic startPor(input logic [2:0] mode, input logic enN);
    @(negedge clk);
    oscMode = mode;
    timerEnN = enN;
    powerOnPulse = 1'b1;
    steps(2);
    chk("R1 stage in POR", stage, S_POR);
    chk("R1 reset in POR", coreReset, 1);
    powerOnPulse = 1'b0;
    edgeIdx = -1;
  endtask

  task automatic checkRelease(input string req, input int t);
    if (t > 0) begin
      stepTo(t - 1);
      chk({req, " held before release"}, int'(stage == S_RUN), 0);
    end
    stepTo(t);
    chk({req, " stage at release"}, stage, S_RUN);
    chk({req, " reset at release"}, coreReset, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    steps(3);

    // R2 R3 R4 R10: full walk in PLL mode
    startPor(3'd3, 1'b0);
    stepTo(0);                         chk("R2 enter PWRT", stage, S_PWRT);
    stepTo(PWRT_LEN);                  chk("R2 still PWRT", stage, S_PWRT);
    stepTo(PWRT_LEN + 1);              chk("R3 enter OST", stage, S_OST);
    stepTo(PWRT_LEN + OST_LEN + 1);    chk("R3 still OST", stage, S_OST);
    stepTo(PWRT_LEN + OST_LEN + 2);    chk("R4 enter PLL", stage, S_PLL);
    stepTo(PWRT_LEN + OST_LEN + LOCK_LEN + 2); chk("R4 still PLL", stage, S_PLL);
    checkRelease("R10 pll", expRelease(3'd3, 1'b0));

    // R5: nothing applies
    startPor(3'd5, 1'b1);
    checkRelease("R5 rc no timer", 0);

    // R1: pulse while running
    @(negedge clk); powerOnPulse = 1'b1;
    @(negedge clk); chk("R1 pulse in RUN", stage, S_POR);
    chk("R1 reset on pulse", coreReset, 1);
    powerOnPulse = 1'b0; steps(2);

    // random configurations, R2 R3 R10
    for (int i = 0; i < 8; i++) begin
      logic [2:0] m;
      logic e;
      m = 3'($urandom_range(0, 7));
      e = 1'($urandom_range(0, 1));
      startPor(m, e);
      stepTo(0);
      chk("R3 first stage random", stage, expFirst(m, e));
      checkRelease("R10 random", expRelease(m, e));
    end

    // R6: filter and enable, from RUN in RC mode without timer
    startPor(3'd4, 1'b1);
    stepTo(0);
    brownEn = 1'b0; lowSupply = 1'b1; steps(20);
    chk("R6 disabled no BOR", stage, S_RUN);
    lowSupply = 1'b0; brownEn = 1'b1; steps(2);
    lowSupply = 1'b1; steps(FILT); lowSupply = 1'b0;
    chk("R6 short dip no BOR", stage, S_RUN);
    steps(3);
    chk("R6 short dip still RUN", stage, S_RUN);
    chk("R6 short dip reset low", coreReset, 0);
    lowSupply = 1'b1; steps(FILT + 1);
    chk("R6 long dip BOR", stage, S_BOR);
    chk("R6 reset in BOR", coreReset, 1);
    steps(10);
    chk("R7 stay BOR", stage, S_BOR);
    lowSupply = 1'b0; steps(1);
    chk("R7 BOR exit no timer", stage, S_RUN);

    // R7 R8: brown-out inside PWRT, full reload, no OST after it
    @(negedge clk); oscMode = 3'd1; timerEnN = 1'b0;
    lowSupply = 1'b1; steps(FILT + 1);
    chk("R8 BOR from RUN", stage, S_BOR);
    lowSupply = 1'b0; edgeIdx = -1;
    stepTo(0);    chk("R7 BOR exit to PWRT", stage, S_PWRT);
    stepTo(1000);
    lowSupply = 1'b1; steps(FILT + 1);
    chk("R8 BOR during PWRT", stage, S_BOR);
    lowSupply = 1'b0; edgeIdx = -1;
    stepTo(0);    chk("R7 reenter PWRT", stage, S_PWRT);
    stepTo(PWRT_LEN); chk("R7 full reload", stage, S_PWRT);
    stepTo(PWRT_LEN + 1);
    chk("R7 no OST after BOR", stage, S_RUN);
    chk("R7 reset released", coreReset, 0);

    // R8: brown-out trip coincides with PWRT completion
    startPor(3'd4, 1'b0);
    stepTo(PWRT_LEN - FILT);
    lowSupply = 1'b1;
    stepTo(PWRT_LEN + 1);
    chk("R8 trip wins over done", stage, S_BOR);
    lowSupply = 1'b0; steps(2);

    // R9: pin held low across all time-outs, then released
    @(negedge clk); extResetN = 1'b0;
    startPor(3'd2, 1'b0);
    stepTo(expRelease(3'd2, 1'b0) + 10);
    chk("R9 stage RUN with pin low", stage, S_RUN);
    chk("R9 reset held by pin", coreReset, 1);
    extResetN = 1'b1;
    steps(1); chk("R9 one edge after pin", coreReset, 1);
    steps(1); chk("R9 two edges after pin", coreReset, 0);
    extResetN = 1'b0; steps(2);
    chk("R9 pin low in RUN", coreReset, 1);
    extResetN = 1'b1; steps(3);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErrors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

endmodule